// File: doc/BRIEF.md
# Double-Precision to Integer Converter with Saturation Override

This unit turns a 64-bit binary floating-point operand into an integer, always discarding the fractional part toward zero. The caller picks a destination width of 16, 32 or 64 bits and whether the result is signed or unsigned. Two conversion modes exist. The clamping mode pins out-of-range values to the nearest limit of the destination range. The wrapping mode keeps only the low bits of the exact truncated integer, the way scripting-language 32-bit integer coercion behaves. An optional saturation override can be added on top. It treats the operation as if it had unlimited width and then clamps the exact result to the range where the operation's own range and the override's range overlap. When the override is on, this clamp takes priority over wrapping.

The datapath is combinational and feeds one output register. A small three-state controller tracks that register. ST_EMPTY is the state after reset, before any result exists. ST_FRESH means a result was captured at the last edge. ST_HELD means an older result is still being presented. From any state, a cycle with `in_valid` high leads to ST_FRESH (transition LOAD). With `in_valid` low, ST_FRESH moves to ST_HELD (transition AGE), ST_HELD stays where it is (transition KEEP), and ST_EMPTY stays where it is (transition WAIT). `out_valid` is high only in ST_FRESH.

Top module: `f2i_convert`

## Requirements
- R1: Every conversion truncates toward zero. In range, 2.5 gives 2 and -2.5 gives -2, and any magnitude below 1 gives 0.
- R2: A NaN operand (exponent field all ones, fraction non-zero) gives 0 in every mode. In clamping mode, +infinity gives the upper limit and -infinity the lower limit. In wrapping mode, either infinity gives 0.
- R3: Clamping mode, signed, width W: results are limited to [-2^(W-1), 2^(W-1)-1]. The largest double below 2^63 converts exactly to 0x7FFFFFFFFFFFFC00, and 2^63 gives 0x7FFFFFFFFFFFFFFF.
- R4: Clamping mode, unsigned, width W: zero, negative values and -infinity give 0. Values at or above 2^W give 2^W-1.
- R5: Wrapping mode, no override: the result is the low W bits of the two's-complement exact truncated integer. Magnitudes below 1, infinities and values whose low W bits are all zero give 0.
- R6: With `in_ovr_en`=1, the exact truncated value is clamped to the overlap of the operation's range and the override's range (signed or unsigned per `in_ovr_signed`, same width W). This applies in both modes and replaces wrapping. For example, unsigned 16-bit with a signed override limits results to 0..0x7FFF.
- R7: `in_width` code 2'b00 selects 16 bits, 2'b01 selects 32 bits, and 2'b10 or 2'b11 select 64 bits. Results narrower than 64 bits are sign-extended when signed and zero-extended when unsigned. `in_mode` 0 selects clamping and 1 selects wrapping.
- R8: A result appears on `out_result` with `out_valid` high exactly one cycle after `in_valid`. `out_valid` is low in cycles that do not follow an accepted input, and `out_result` holds its value until the next accepted input.
- R9: During and after reset, `out_valid` is 0 and `out_result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Operand and selects are taken this cycle |
| in_operand | input | 64 | Binary64 floating-point operand |
| in_mode | input | 1 | 0 clamping, 1 wrapping |
| in_width | input | 2 | Destination width code |
| in_signed | input | 1 | 1 for a signed destination |
| in_ovr_en | input | 1 | Enables the saturation override |
| in_ovr_signed | input | 1 | Override range is signed when 1 |
| out_valid | output | 1 | Result captured at the last edge |
| out_result | output | 64 | Extended integer result |

## Verification
The two functions that can act on the same operand in the same cycle are modular wrapping and the saturation override. An out-of-range operand is sent in wrapping mode with the override enabled. It is judged correct only if the output equals the clamped limit and not the wrapped low bits. The same operand is also sent without the override, and that result must be the wrapped value, so both behaviours are checked on identical input. A second overlap, between a new accepted input and a held result, is provoked by back-to-back and gapped valids.

// File: rtl/f2i_pkg.sv
package f2i_pkg;

    localparam int unsigned DBL_EXP_W  = 11;
    localparam int unsigned DBL_FRAC_W = 52;
    localparam int unsigned INT_W      = 64;
    localparam int unsigned N_SLOTS    = 4;   // width-index slots (three used, last mirrors 64)

    // R7: destination width codes
    typedef enum logic [1:0] {
        WD_16     = 2'b00,
        WD_32     = 2'b01,
        WD_64     = 2'b10,
        WD_64_ALT = 2'b11
    } width_e;

    typedef enum logic {
        MD_CLAMP = 1'b0,
        MD_WRAP  = 1'b1
    } mode_e;

    typedef enum logic [1:0] {
        ST_EMPTY = 2'd0,
        ST_FRESH = 2'd1,
        ST_HELD  = 2'd2
    } stage_e;

    function automatic logic [1:0] width_index(input logic [1:0] code);
        case (width_e'(code))
            WD_16:   return 2'd0;
            WD_32:   return 2'd1;
            default: return 2'd2;
        endcase
    endfunction

endpackage

// File: rtl/f2i_unpack.sv
module f2i_unpack
    import f2i_pkg::*;
#(
    parameter int unsigned EXP_W  = DBL_EXP_W,
    parameter int unsigned FRAC_W = DBL_FRAC_W,
    parameter int unsigned RES_W  = INT_W
) (
    input  logic [EXP_W+FRAC_W:0] operand,
    output logic                  sign,
    output logic                  is_nan,
    output logic                  is_inf,
    output logic                  big,
    output logic [RES_W-1:0]      mag_low
);

    localparam int unsigned BIAS   = (1 << (EXP_W - 1)) - 1;
    localparam int unsigned E_W    = EXP_W + 1;
    localparam int unsigned SPAN   = FRAC_W + RES_W;
    localparam int unsigned SH_W   = $clog2(SPAN);
    localparam int unsigned WIDE_W = FRAC_W + 1 + SPAN;

    localparam logic signed [E_W-1:0] BIAS_S = E_W'(BIAS);
    localparam logic signed [E_W-1:0] SPAN_S = E_W'(SPAN);
    localparam logic signed [E_W-1:0] BIG_S  = E_W'(RES_W);

    logic [EXP_W-1:0]        bexp;
    logic [FRAC_W-1:0]       frac;
    logic [FRAC_W:0]         mant;
    logic signed [E_W-1:0]   e_unb;
    logic [SH_W-1:0]         shamt;
    logic                    special;

    assign sign    = operand[EXP_W+FRAC_W];
    assign bexp    = operand[FRAC_W +: EXP_W];
    assign frac    = operand[FRAC_W-1:0];
    assign mant    = {1'b1, frac};
    assign special = &bexp;
    assign is_nan  = special && (|frac);    // R2
    assign is_inf  = special && !(|frac);

    assign e_unb = $signed({1'b0, bexp}) - BIAS_S;
    assign shamt = e_unb[SH_W-1:0];

    // Low bits of the truncated magnitude (R1, R5): the implicit one lands at
    // bit e, fraction bits below bit 0 are dropped.
    always_comb begin
        if (special || (e_unb < 0) || (e_unb >= SPAN_S)) begin
            mag_low = '0;
        end else begin
            mag_low = RES_W'((WIDE_W'(mant) << shamt) >> FRAC_W);
        end
    end

    // Magnitude reaches 2^RES_W: exceeds every destination range
    assign big = !special && (e_unb >= BIG_S);

endmodule

// File: rtl/f2i_bounds.sv
module f2i_bounds
    import f2i_pkg::*;
#(
    parameter int unsigned RES_W = INT_W
) (
    input  logic [1:0]             width_idx,
    input  logic                   op_signed,
    input  logic                   ovr_en,
    input  logic                   ovr_signed,
    output logic signed [RES_W+1:0] lim_lo,
    output logic signed [RES_W+1:0] lim_hi
);

    localparam int unsigned EXT_W = RES_W + 2;
    localparam logic signed [EXT_W-1:0] ONE = EXT_W'(1);

    logic signed [EXT_W-1:0] s_hi [N_SLOTS];
    logic signed [EXT_W-1:0] s_lo [N_SLOTS];
    logic signed [EXT_W-1:0] u_hi [N_SLOTS];
    logic signed [EXT_W-1:0] op_lo, op_hi, ov_lo, ov_hi;

    // One set of limits per destination width: quarter, half and full
    for (genvar g = 0; g < 3; g++) begin : g_lim
        localparam int unsigned BITS = (RES_W / 4) << g;
        assign s_hi[g] = (ONE <<< (BITS - 1)) - ONE;    // R3
        assign s_lo[g] = -(ONE <<< (BITS - 1));         // R3
        assign u_hi[g] = (ONE <<< BITS) - ONE;          // R4
    end
    assign s_hi[3] = s_hi[2];
    assign s_lo[3] = s_lo[2];
    assign u_hi[3] = u_hi[2];

    always_comb begin
        op_lo = op_signed  ? s_lo[width_idx] : '0;
        op_hi = op_signed  ? s_hi[width_idx] : u_hi[width_idx];
        ov_lo = ovr_signed ? s_lo[width_idx] : '0;
        ov_hi = ovr_signed ? s_hi[width_idx] : u_hi[width_idx];
        if (ovr_en) begin
            // R6: overlap of both ranges
            lim_lo = (ov_lo > op_lo) ? ov_lo : op_lo;
            lim_hi = (ov_hi < op_hi) ? ov_hi : op_hi;
        end else begin
            lim_lo = op_lo;
            lim_hi = op_hi;
        end
    end

endmodule

// File: rtl/f2i_resolve.sv
module f2i_resolve
    import f2i_pkg::*;
#(
    parameter int unsigned RES_W = INT_W
) (
    input  logic                    sign,
    input  logic                    is_nan,
    input  logic                    is_inf,
    input  logic                    big,
    input  logic [RES_W-1:0]        mag_low,
    input  logic                    mode,
    input  logic [1:0]              width_idx,
    input  logic                    op_signed,
    input  logic                    ovr_en,
    input  logic signed [RES_W+1:0] lim_lo,
    input  logic signed [RES_W+1:0] lim_hi,
    output logic [RES_W-1:0]        result
);

    localparam int unsigned EXT_W = RES_W + 2;

    logic signed [EXT_W-1:0] exact;
    logic [RES_W-1:0]        clamp_res;
    logic [RES_W-1:0]        wrap_res;
    logic [RES_W-1:0]        twos;
    logic [RES_W-1:0]        narrowed [N_SLOTS];

    // Exact value; only meaningful when the magnitude is below 2^RES_W
    assign exact = sign ? -$signed({2'b00, mag_low}) : $signed({2'b00, mag_low});

    // Clamping path (R2, R3, R4, R6)
    always_comb begin
        if (is_nan) begin
            clamp_res = '0;
        end else if (is_inf || big) begin
            clamp_res = sign ? lim_lo[RES_W-1:0] : lim_hi[RES_W-1:0];
        end else if (exact > lim_hi) begin
            clamp_res = lim_hi[RES_W-1:0];
        end else if (exact < lim_lo) begin
            clamp_res = lim_lo[RES_W-1:0];
        end else begin
            clamp_res = exact[RES_W-1:0];
        end
    end

    // Wrapping path (R5, R7)
    assign twos = sign ? (~mag_low + RES_W'(1)) : mag_low;

    for (genvar g = 0; g < 3; g++) begin : g_narrow
        localparam int unsigned BITS = (RES_W / 4) << g;
        if (BITS >= RES_W) begin : g_full
            assign narrowed[g] = twos;
        end else begin : g_part
            assign narrowed[g] = op_signed
                ? {{(RES_W - BITS){twos[BITS-1]}}, twos[BITS-1:0]}
                : {{(RES_W - BITS){1'b0}}, twos[BITS-1:0]};
        end
    end
    assign narrowed[3] = narrowed[2];

    assign wrap_res = (is_nan || is_inf) ? '0 : narrowed[width_idx];

    // R6: the override takes priority over wrapping
    assign result = ((mode_e'(mode) == MD_CLAMP) || ovr_en) ? clamp_res : wrap_res;

endmodule

// File: rtl/f2i_convert.sv
module f2i_convert
    import f2i_pkg::*;
#(
    parameter int unsigned EXP_W  = DBL_EXP_W,
    parameter int unsigned FRAC_W = DBL_FRAC_W,
    parameter int unsigned RES_W  = INT_W
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [EXP_W+FRAC_W:0]  in_operand,
    input  logic                   in_mode,
    input  logic [1:0]             in_width,
    input  logic                   in_signed,
    input  logic                   in_ovr_en,
    input  logic                   in_ovr_signed,
    output logic                   out_valid,
    output logic [RES_W-1:0]       out_result
);

    localparam int unsigned EXT_W = RES_W + 2;

    logic                    u_sign, u_nan, u_inf, u_big;
    logic [RES_W-1:0]        u_mag;
    logic [1:0]              w_idx;
    logic signed [EXT_W-1:0] b_lo, b_hi;
    logic [RES_W-1:0]        res_d, res_q;
    stage_e                  st_q, st_nxt;

    assign w_idx = width_index(in_width);

    f2i_unpack #(
        .EXP_W  (EXP_W),
        .FRAC_W (FRAC_W),
        .RES_W  (RES_W)
    ) i_unpack (
        .operand (in_operand),
        .sign    (u_sign),
        .is_nan  (u_nan),
        .is_inf  (u_inf),
        .big     (u_big),
        .mag_low (u_mag)
    );

    f2i_bounds #(
        .RES_W (RES_W)
    ) i_bounds (
        .width_idx  (w_idx),
        .op_signed  (in_signed),
        .ovr_en     (in_ovr_en),
        .ovr_signed (in_ovr_signed),
        .lim_lo     (b_lo),
        .lim_hi     (b_hi)
    );

    f2i_resolve #(
        .RES_W (RES_W)
    ) i_resolve (
        .sign      (u_sign),
        .is_nan    (u_nan),
        .is_inf    (u_inf),
        .big       (u_big),
        .mag_low   (u_mag),
        .mode      (in_mode),
        .width_idx (w_idx),
        .op_signed (in_signed),
        .ovr_en    (in_ovr_en),
        .lim_lo    (b_lo),
        .lim_hi    (b_hi),
        .result    (res_d)
    );

    // State register (R8, R9)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_EMPTY;
        end else begin
            st_q <= st_nxt;
        end
    end

    // Next state: LOAD, AGE, KEEP, WAIT
    always_comb begin
        st_nxt = st_q;
        unique case (st_q)
            ST_EMPTY: st_nxt = in_valid ? ST_FRESH : ST_EMPTY;
            ST_FRESH: st_nxt = in_valid ? ST_FRESH : ST_HELD;
            ST_HELD:  st_nxt = in_valid ? ST_FRESH : ST_HELD;
            default:  st_nxt = ST_EMPTY;
        endcase
    end

    // Result register: captured only on an accepted input (R8)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= '0;
        end else if (in_valid) begin
            res_q <= res_d;
        end
    end

    // Outputs
    always_comb begin
        out_result = res_q;
        unique case (st_q)
            ST_FRESH: out_valid = 1'b1;
            default:  out_valid = 1'b0;
        endcase
    end

endmodule

// File: rtl/f2i_checker.sv
module f2i_checker
    import f2i_pkg::*;
#(
    parameter int unsigned EXP_W  = DBL_EXP_W,
    parameter int unsigned FRAC_W = DBL_FRAC_W,
    parameter int unsigned RES_W  = INT_W
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  in_valid,
    input logic [EXP_W+FRAC_W:0] in_operand,
    input logic                  in_mode,
    input logic [1:0]            in_width,
    input logic                  in_signed,
    input logic                  in_ovr_en,
    input logic                  in_ovr_signed,
    input logic                  out_valid,
    input logic [RES_W-1:0]      out_result
);

    logic op_nan;
    assign op_nan = (&in_operand[FRAC_W +: EXP_W]) && (|in_operand[FRAC_W-1:0]);

    AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid) else $error("result not flagged one cycle after input"); // R8

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid) else $error("out_valid without input"); // R8

    AST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_result)) else $error("result changed while idle"); // R8

    AST_NAN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && op_nan) |=> (out_result == '0)) else $error("NaN not zero"); // R2

    AST_SEXT_32: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_signed && in_width == 2'b01)
        |=> ((&out_result[RES_W-1:31]) || (out_result[RES_W-1:31] == '0)))
        else $error("32-bit signed result not sign-extended"); // R7

    AST_ZEXT_16: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_signed && in_width == 2'b00) |=> (out_result[RES_W-1:16] == '0))
        else $error("16-bit unsigned result not zero-extended"); // R7

    AST_UNS_NEG_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_mode == 1'b0 && !in_signed && in_operand[EXP_W+FRAC_W] && !op_nan)
        |=> (out_result == '0)) else $error("negative unsigned clamp not zero"); // R4

    AST_OVR_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ovr_en && in_ovr_signed && !in_signed && in_width == 2'b00)
        |=> (out_result <= RES_W'(16'h7FFF))) else $error("override limit exceeded"); // R6

endmodule

bind f2i_convert f2i_checker i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .in_valid      (in_valid),
    .in_operand    (in_operand),
    .in_mode       (in_mode),
    .in_width      (in_width),
    .in_signed     (in_signed),
    .in_ovr_en     (in_ovr_en),
    .in_ovr_signed (in_ovr_signed),
    .out_valid     (out_valid),
    .out_result    (out_result)
);

// File: tb/test_f2i_convert.sv
module test_f2i_convert;

    typedef struct packed {
        logic [63:0] op;
        logic        md;
        logic [1:0]  wd;
        logic        sg;
        logic        oe;
        logic        os;
        logic [63:0] xp;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 34;
    localparam vec_t VECS [NV] = '{
        '{64'h4004000000000000, 1'b0, 2'b01, 1'b1, 1'b0, 1'b0, 64'h0000000000000002, 8'd1}, // R1 2.5
        '{64'hC004000000000000, 1'b0, 2'b01, 1'b1, 1'b0, 1'b0, 64'hFFFFFFFFFFFFFFFE, 8'd1}, // R1 -2.5
        '{64'h3FE8000000000000, 1'b0, 2'b10, 1'b1, 1'b0, 1'b0, 64'h0000000000000000, 8'd1}, // R1 0.75
        '{64'hBFE8000000000000, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 64'h0000000000000000, 8'd4}, // R4 -0.75
        '{64'h7FF8000000000000, 1'b0, 2'b10, 1'b1, 1'b0, 1'b0, 64'h0000000000000000, 8'd2}, // R2 NaN clamp
        '{64'h7FF8000000000000, 1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 64'h0000000000000000, 8'd2}, // R2 NaN wrap
        '{64'h7FF0000000000000, 1'b0, 2'b10, 1'b1, 1'b0, 1'b0, 64'h7FFFFFFFFFFFFFFF, 8'd2}, // R2 +inf
        '{64'hFFF0000000000000, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 64'hFFFFFFFFFFFF8000, 8'd2}, // R2 -inf s16
        '{64'h7FF0000000000000, 1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 64'h0000000000000000, 8'd5}, // R5 inf wrap
        '{64'h43E0000000000000, 1'b0, 2'b10, 1'b1, 1'b0, 1'b0, 64'h7FFFFFFFFFFFFFFF, 8'd3}, // R3 2^63
        '{64'h43DFFFFFFFFFFFFF, 1'b0, 2'b10, 1'b1, 1'b0, 1'b0, 64'h7FFFFFFFFFFFFC00, 8'd3}, // R3 below 2^63
        '{64'hC3E0000000000000, 1'b0, 2'b10, 1'b1, 1'b0, 1'b0, 64'h8000000000000000, 8'd3}, // R3 -2^63
        '{64'h41DFFFFFFFC00000, 1'b0, 2'b01, 1'b1, 1'b0, 1'b0, 64'h000000007FFFFFFF, 8'd3}, // R3 2^31-1
        '{64'h41E0000000000000, 1'b0, 2'b01, 1'b1, 1'b0, 1'b0, 64'h000000007FFFFFFF, 8'd3}, // R3 2^31
        '{64'h41E65A0BC0000000, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 64'h00000000B2D05E00, 8'd4}, // R4 3e9 u32
        '{64'h41F0000000000000, 1'b0, 2'b01, 1'b0, 1'b0, 1'b0, 64'h00000000FFFFFFFF, 8'd4}, // R4 2^32 u32
        '{64'h43F0000000000000, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 64'hFFFFFFFFFFFFFFFF, 8'd4}, // R4 2^64 u64
        '{64'hBFF0000000000000, 1'b0, 2'b10, 1'b0, 1'b0, 1'b0, 64'h0000000000000000, 8'd4}, // R4 -1 u64
        '{64'h41E65A0BC0000000, 1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 64'hFFFFFFFFB2D05E00, 8'd5}, // R5 3e9 wrap
        '{64'h41F0000000500000, 1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 64'h0000000000000005, 8'd5}, // R5 2^32+5
        '{64'hC1F0000000500000, 1'b1, 2'b01, 1'b1, 1'b0, 1'b0, 64'hFFFFFFFFFFFFFFFB, 8'd5}, // R5 -(2^32+5)
        '{64'hC1F0000000500000, 1'b1, 2'b01, 1'b0, 1'b0, 1'b0, 64'h00000000FFFFFFFB, 8'd7}, // R7 zext u32
        '{64'h40E3880000000000, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 64'h0000000000007FFF, 8'd3}, // R3 40000 s16
        '{64'h40E3880000000000, 1'b1, 2'b00, 1'b1, 1'b0, 1'b0, 64'hFFFFFFFFFFFF9C40, 8'd5}, // R5 40000 wrap s16
        '{64'h40E3880000000000, 1'b0, 2'b00, 1'b0, 1'b1, 1'b1, 64'h0000000000007FFF, 8'd6}, // R6 u16 + s ovr
        '{64'h40E3880000000000, 1'b1, 2'b00, 1'b0, 1'b1, 1'b1, 64'h0000000000007FFF, 8'd6}, // R6 beats wrap
        '{64'hBFF0000000000000, 1'b0, 2'b00, 1'b1, 1'b1, 1'b0, 64'h0000000000000000, 8'd6}, // R6 s16 + u ovr
        '{64'h40E3880000000000, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 64'h0000000000009C40, 8'd4}, // R4 40000 u16
        '{64'h40F0000000000000, 1'b1, 2'b00, 1'b0, 1'b0, 1'b0, 64'h0000000000000000, 8'd5}, // R5 65536 u16
        '{64'h41E0000000000000, 1'b0, 2'b01, 1'b1, 1'b1, 1'b1, 64'h000000007FFFFFFF, 8'd6}, // R6 same-sign ovr
        '{64'hC004000000000000, 1'b1, 2'b11, 1'b1, 1'b0, 1'b0, 64'hFFFFFFFFFFFFFFFE, 8'd7}, // R7 code 11 = 64
        '{64'h41E65A0BC0000000, 1'b1, 2'b01, 1'b0, 1'b1, 1'b0, 64'h00000000B2D05E00, 8'd6}, // R6 in range
        '{64'h43F0000000000000, 1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 64'h0000000000000000, 8'd5}, // R5 2^64 wrap
        '{64'h43E0000000000000, 1'b1, 2'b10, 1'b1, 1'b0, 1'b0, 64'h8000000000000000, 8'd5}  // R5 2^63 wrap
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [63:0] in_operand = '0;
    logic        in_mode = 1'b0;
    logic [1:0]  in_width = 2'b00;
    logic        in_signed = 1'b0;
    logic        in_ovr_en = 1'b0;
    logic        in_ovr_signed = 1'b0;
    logic        out_valid;
    logic [63:0] out_result;

    int n_checks = 0;
    int n_errors = 0;

    always #4 clk = ~clk;

    f2i_convert i_f2i_convert (
        .clk           (clk),
        .rst_n         (rst_n),
        .in_valid      (in_valid),
        .in_operand    (in_operand),
        .in_mode       (in_mode),
        .in_width      (in_width),
        .in_signed     (in_signed),
        .in_ovr_en     (in_ovr_en),
        .in_ovr_signed (in_ovr_signed),
        .out_valid     (out_valid),
        .out_result    (out_result)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        in_operand    = v.op;
        in_mode       = v.md;
        in_width      = v.wd;
        in_signed     = v.sg;
        in_ovr_en     = v.oe;
        in_ovr_signed = v.os;
        in_valid      = 1'b1;
    endtask

    initial begin
        #(8 * 100000);
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        // R9: reset state
        repeat (3) @(negedge clk);
        check("R9 valid in reset", {63'b0, out_valid}, 64'd0);
        check("R9 result in reset", out_result, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 valid after reset", {63'b0, out_valid}, 64'd0);

        // Table walk
        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            @(negedge clk);
            in_valid = 1'b0;
            check($sformatf("R8 valid vec %0d", i), {63'b0, out_valid}, 64'd1);
            check($sformatf("R%0d vec %0d", VECS[i].rq, i), out_result, VECS[i].xp);
        end

        // R8: hold while idle, stimulus changes must not matter
        drive(VECS[0]);
        @(negedge clk);
        in_valid   = 1'b0;
        in_operand = 64'h43E0000000000000;
        in_signed  = 1'b0;
        check("R8 fresh", out_result, 64'd2);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R8 idle valid", {63'b0, out_valid}, 64'd0);
            check("R8 held result", out_result, 64'd2);
        end

        // R8: back-to-back inputs, each one cycle later
        drive(VECS[1]);
        @(negedge clk);
        check("R8 b2b first", out_result, VECS[1].xp);
        drive(VECS[6]);
        @(negedge clk);
        check("R8 b2b second", out_result, VECS[6].xp);
        check("R8 b2b valid", {63'b0, out_valid}, 64'd1);
        drive(VECS[25]);
        @(negedge clk);
        in_valid = 1'b0;
        check("R6 b2b override", out_result, 64'h7FFF);

        // R9: reset in the middle of a run clears the output
        @(negedge clk);
        rst_n = 1'b0;
        #1;
        check("R9 async clear", out_result, 64'd0);
        check("R9 async valid", {63'b0, out_valid}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R9 stays empty", {63'b0, out_valid}, 64'd0);

        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule